// File: doc/BRIEF.md
# Real-Mode Segmented Memory Access Unit

This unit connects an 8086-class execution core to a byte-wide memory of one megabyte. It holds a shadow base address for each of the four segment registers, and it forms 20-bit physical addresses from a segment choice and a 16-bit offset. It then runs byte or 16-bit word accesses as a series of single-byte memory cycles. A word access is always split into two byte cycles, with the low byte first.

The second byte of a word does not always sit one address above the first. If the offset is 0xFFFF, the high byte wraps to offset 0 of the same segment. If the physical address is 0xFFFFF, the high byte wraps to physical 0. A read-modify-write access reads both bytes, holds them for the core, and then writes new data back to the same two addresses.

The core writes segment values on a separate port. Each request names a segment, or leaves it unnamed so that the data segment is used. The memory port is a plain synchronous RAM interface: read data comes back in the cycle after the address.

Top module: `seg_mem_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `done`, `mem_en` and `wb_wait` are 0, the code segment holds 0xFFFF and the other segments hold 0. As a result, a byte read of the code segment at offset 0 goes to physical 0xFFFF0.
- R2: A write on the segment port sets that segment's base to the value shifted left by 4 bits. The new base applies to requests accepted on later clock edges. A request accepted on the same edge as the write still uses the old base.
- R3: The physical address is the segment base plus the offset, truncated to 20 bits. A byte access makes exactly one memory cycle at that address. A byte read returns the byte in `rdata[7:0]` with zeros above it, and a byte write stores `req_wdata[7:0]`.
- R4: The segment code on `req_seg_sel` is 0 for extra, 1 for code, 2 for stack and 3 for data. When `req_seg_named` is 0, the data segment is used whatever `req_seg_sel` holds.
- R5: A word access makes two memory cycles, the low byte first. The low byte is at the physical address and the high byte is at that address plus 1. Read data is little-endian: the byte from the first cycle goes in `rdata[7:0]`.
- R6: When the offset is 0xFFFF, a word's high byte comes from the segment base, which is offset 0 of the same segment. This applies even if the physical address is also 0xFFFFF.
- R7: When the word's physical address is 0xFFFFF and the offset is not 0xFFFF, the high byte comes from physical 0x00000.
- R8: `req_ready` goes low on the edge after a request is accepted. For reads and writes, `done` is high for exactly one cycle. It rises 2 edges after acceptance for a byte access and 3 edges after acceptance for a word access.
- R9: A read-modify-write access (`req_op` = 2) first reads its byte or bytes. It then holds `wb_wait` high with the read value on `rdata`. On the edge where `wb_valid` is sampled, it takes `wb_data` and writes it back, low byte first, to the same addresses. `done` pulses after the last write.
- R10: `mem_we` is only ever high together with `mem_en`. No memory cycle runs while the unit is idle or while `wb_wait` is high.
- R11: A word write (`req_op` = 1) stores `req_wdata[7:0]` at the low address and `req_wdata[15:8]` at the high address. `req_op` = 0 is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment to write (0 extra, 1 code, 2 stack, 3 data) |
| seg_wr_val | input | 16 | New segment value |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Unit idle; a request is accepted when this and `req_valid` are both high |
| req_seg_named | input | 1 | 1: use `req_seg_sel`; 0: use the data segment |
| req_seg_sel | input | 2 | Segment chosen for the request |
| req_offset | input | 16 | Offset within the segment |
| req_op | input | 2 | 0 read, 1 write, 2 read-modify-write |
| req_word | input | 1 | 1: 16-bit word; 0: byte |
| req_wdata | input | 16 | Write data |
| wb_valid | input | 1 | Write-back data valid for read-modify-write |
| wb_data | input | 16 | Write-back data |
| wb_wait | output | 1 | Read phase of a read-modify-write is done; waiting for write-back data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result |
| mem_en | output | 1 | Memory cycle enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 20 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid in the cycle after the address |

## Verification
An accepted request produces its `done` pulse 2 edges later for a byte access and 3 edges later for a word access. The bench counts edges from the accepting edge and checks for these exact numbers. A bench memory model records every memory cycle at the clock edge where it occurs, so address order, write data and the number of cycles are compared only after completion. All outputs are sampled on the falling edge. For read-modify-write, `rdata` is checked while `wb_wait` is high, and the bench stalls for several cycles to confirm that no memory cycle occurs before it supplies the write-back data.

// File: rtl/seg_mem_pkg.sv
package seg_mem_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RMW   = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RLO,
    ST_RHI,
    ST_RFIN,
    ST_WAITWB,
    ST_WLO,
    ST_WHI,
    ST_WFIN
  } acc_state_e;

endpackage

// File: rtl/seg_base_file.sv
module seg_base_file #(
  parameter int SEG_W        = 16,
  parameter int ADDR_W       = 20,
  parameter int NUM_SEGS     = 4,
  parameter int RESET_SEG    = 1,
  parameter int RESET_VAL    = 16'hFFFF,
  localparam int SEL_W       = $clog2(NUM_SEGS),
  localparam int SHIFT       = ADDR_W - SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [SEG_W-1:0]  wr_val,
  output logic [ADDR_W-1:0] base_o [NUM_SEGS]
);

  function automatic logic [ADDR_W-1:0] to_base(input logic [SEG_W-1:0] s);
    return ADDR_W'(s) << SHIFT;
  endfunction

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    localparam logic [SEG_W-1:0] INIT = (g == RESET_SEG) ? SEG_W'(RESET_VAL) : '0;
    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        base_q <= to_base(INIT);
      else if (wr_en && (wr_sel == SEL_W'(g)))
        base_q <= to_base(wr_val);
    end

    assign base_o[g] = base_q;
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int ADDR_W = 20,
  parameter int OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] lo_addr,
  output logic [ADDR_W-1:0] hi_addr,
  output logic              hi_from_base
);

  function automatic logic [ADDR_W-1:0] form_phys(input logic [ADDR_W-1:0] b,
                                                 input logic [OFF_W-1:0]  o);
    return b + ADDR_W'(o);
  endfunction

  function automatic logic [ADDR_W-1:0] next_phys(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  always_comb begin
    lo_addr      = form_phys(base, offset);
    hi_from_base = &offset;
    hi_addr      = hi_from_base ? form_phys(base, '0) : next_phys(lo_addr);
  end

endmodule

// File: rtl/seg_access_fsm.sv
module seg_access_fsm
  import seg_mem_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  op_e               req_op,
  input  logic              req_word,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [ADDR_W-1:0] lo_addr,
  input  logic [ADDR_W-1:0] hi_addr,
  input  logic              hi_from_base,
  input  logic              wb_valid,
  input  logic [WORD_W-1:0] wb_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              req_ready,
  output logic              req_accept,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              done,
  output logic [WORD_W-1:0] rdata,
  output logic              wb_wait,
  output logic              second_byte,
  output logic              hi_wrap_q
);

  acc_state_e        state_q;
  logic [ADDR_W-1:0] lo_q, hi_q;
  logic              word_q;
  op_e               op_q;
  logic [WORD_W-1:0] wdat_q;
  logic [DATA_W-1:0] lo_byte_q;
  logic [WORD_W-1:0] rdata_q;
  logic              done_q;
  logic              wrap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      lo_q      <= '0;
      hi_q      <= '0;
      word_q    <= 1'b0;
      op_q      <= OP_READ;
      wdat_q    <= '0;
      lo_byte_q <= '0;
      rdata_q   <= '0;
      done_q    <= 1'b0;
      wrap_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            lo_q    <= lo_addr;
            hi_q    <= hi_addr;
            wrap_q  <= hi_from_base;
            word_q  <= req_word;
            op_q    <= req_op;
            wdat_q  <= req_wdata;
            state_q <= (req_op == OP_WRITE) ? ST_WLO : ST_RLO;
          end
        end
        ST_RLO:  state_q <= word_q ? ST_RHI : ST_RFIN;
        ST_RHI: begin
          lo_byte_q <= mem_rdata;
          state_q   <= ST_RFIN;
        end
        ST_RFIN: begin
          rdata_q <= word_q ? {mem_rdata, lo_byte_q} : {{DATA_W{1'b0}}, mem_rdata};
          if (op_q == OP_RMW) begin
            state_q <= ST_WAITWB;
          end else begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_WAITWB: begin
          if (wb_valid) begin
            wdat_q  <= wb_data;
            state_q <= ST_WLO;
          end
        end
        ST_WLO:  state_q <= word_q ? ST_WHI : ST_WFIN;
        ST_WHI:  state_q <= ST_WFIN;
        ST_WFIN: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready   = (state_q == ST_IDLE);
    req_accept  = req_valid && req_ready;
    second_byte = (state_q == ST_RHI) || (state_q == ST_WHI);
    mem_we      = (state_q == ST_WLO) || (state_q == ST_WHI);
    mem_en      = mem_we || (state_q == ST_RLO) || (state_q == ST_RHI);
    mem_addr    = second_byte ? hi_q : lo_q;
    mem_wdata   = (state_q == ST_WHI) ? wdat_q[WORD_W-1:DATA_W] : wdat_q[DATA_W-1:0];
    wb_wait     = (state_q == ST_WAITWB);
    done        = done_q;
    rdata       = rdata_q;
    hi_wrap_q   = wrap_q;
  end

endmodule

// File: rtl/seg_mem_unit.sv
module seg_mem_unit
  import seg_mem_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int SEG_W       = 16,
  parameter int OFF_W       = 16,
  parameter int DATA_W      = 8,
  parameter int NUM_SEGS    = 4,
  parameter int DEFAULT_SEG = 3,
  parameter int RESET_SEG   = 1,
  parameter int RESET_VAL   = 16'hFFFF,
  localparam int SEL_W      = $clog2(NUM_SEGS),
  localparam int WORD_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_wr_en,
  input  logic [SEL_W-1:0]  seg_wr_sel,
  input  logic [SEG_W-1:0]  seg_wr_val,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_seg_named,
  input  logic [SEL_W-1:0]  req_seg_sel,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [1:0]        req_op,
  input  logic              req_word,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              wb_valid,
  input  logic [WORD_W-1:0] wb_data,
  output logic              wb_wait,
  output logic              done,
  output logic [WORD_W-1:0] rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic [ADDR_W-1:0] bases [NUM_SEGS];
  logic [SEL_W-1:0]  eff_sel;
  logic [ADDR_W-1:0] sel_base;
  logic [ADDR_W-1:0] lo_addr, hi_addr;
  logic              hi_from_base;
  logic              req_accept;
  logic              second_byte;
  logic              hi_wrap_q;

  seg_base_file #(
    .SEG_W(SEG_W), .ADDR_W(ADDR_W), .NUM_SEGS(NUM_SEGS),
    .RESET_SEG(RESET_SEG), .RESET_VAL(RESET_VAL)
  ) u_bases (
    .clk(clk), .rst_n(rst_n),
    .wr_en(seg_wr_en), .wr_sel(seg_wr_sel), .wr_val(seg_wr_val),
    .base_o(bases)
  );

  assign eff_sel  = req_seg_named ? req_seg_sel : SEL_W'(DEFAULT_SEG);
  assign sel_base = bases[eff_sel];

  seg_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .base(sel_base), .offset(req_offset),
    .lo_addr(lo_addr), .hi_addr(hi_addr), .hi_from_base(hi_from_base)
  );

  seg_access_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(op_e'(req_op)), .req_word(req_word),
    .req_wdata(req_wdata),
    .lo_addr(lo_addr), .hi_addr(hi_addr), .hi_from_base(hi_from_base),
    .wb_valid(wb_valid), .wb_data(wb_data), .mem_rdata(mem_rdata),
    .req_ready(req_ready), .req_accept(req_accept),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(done), .rdata(rdata), .wb_wait(wb_wait),
    .second_byte(second_byte), .hi_wrap_q(hi_wrap_q)
  );

endmodule

// File: rtl/seg_mem_unit_chk.sv
module seg_mem_unit_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_accept,
  input logic              req_ready,
  input logic              done,
  input logic              wb_wait,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              second_byte,
  input logic              hi_wrap_q
);

  // R10
  we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  // R10
  quiet_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_wait |-> !mem_en);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> !req_ready);

  // R5
  hi_follows_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (second_byte && !hi_wrap_q) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

endmodule

bind seg_mem_unit seg_mem_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_accept(req_accept), .req_ready(req_ready),
  .done(done), .wb_wait(wb_wait), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr), .second_byte(second_byte), .hi_wrap_q(hi_wrap_q)
);

// File: tb/seg_mem_unit_bench.sv
module seg_mem_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = '0;
  logic [15:0] seg_wr_val = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_seg_named = 1'b0;
  logic [1:0]  req_seg_sel = '0;
  logic [15:0] req_offset = '0;
  logic [1:0]  req_op = '0;
  logic        req_word = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        wb_valid = 1'b0;
  logic [15:0] wb_data = '0;
  logic        wb_wait;
  logic        done;
  logic [15:0] rdata;
  logic        mem_en, mem_we;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  seg_mem_unit u_seg_mem_unit (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_val(seg_wr_val),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_seg_named(req_seg_named), .req_seg_sel(req_seg_sel),
    .req_offset(req_offset), .req_op(req_op), .req_word(req_word),
    .req_wdata(req_wdata), .wb_valid(wb_valid), .wb_data(wb_data),
    .wb_wait(wb_wait), .done(done), .rdata(rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Memory model: bytes not yet written hold a fixed pattern.
  logic [7:0] store [int];
  int         log_addr [$];
  bit         log_we   [$];
  logic [7:0] log_data [$];

  function automatic logic [7:0] pat(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
  endfunction

  function automatic logic [7:0] peek(input logic [19:0] a);
    if (store.exists(int'(a))) return store[int'(a)];
    return pat(a);
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      log_addr.push_back(int'(mem_addr));
      log_we.push_back(mem_we);
      log_data.push_back(mem_we ? mem_wdata : 8'h00);
      if (mem_we) store[int'(mem_addr)] = mem_wdata;
      else        mem_rdata <= peek(mem_addr);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic seg_write(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_val = val;
    @(posedge clk);
    @(negedge clk);
    seg_wr_en = 1'b0;
  endtask

  // Issues one request; returns the read data and the count of edges
  // from the accepting edge to the one after which done is high.
  task automatic access(input bit named, input logic [1:0] sel, input logic [15:0] off,
                        input logic [1:0] op, input bit word, input logic [15:0] wd,
                        input bit also_seg, input logic [15:0] seg_val,
                        output logic [15:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_seg_named = named; req_seg_sel = sel;
    req_offset = off; req_op = op; req_word = word; req_wdata = wd;
    if (also_seg) begin
      seg_wr_en = 1'b1; seg_wr_sel = 2'd3; seg_wr_val = seg_val;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; seg_wr_en = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    rd = rdata;
  endtask

  localparam int NV = 8;
  // {named, sel, offset, word, low address, high address}
  localparam logic [59:0] VEC [NV] = '{
    {1'b1, 2'd0, 16'h0010, 1'b0, 20'h12350, 20'h00000},  // R3 R4 extra seg byte
    {1'b0, 2'd1, 16'h0005, 1'b1, 20'h01005, 20'h01006},  // R4 unnamed -> data seg
    {1'b1, 2'd2, 16'hFFFF, 1'b1, 20'hFFFFF, 20'hF0000},  // R6 offset wrap wins
    {1'b1, 2'd1, 16'h000F, 1'b1, 20'hFFFFF, 20'h00000},  // R7 physical wrap
    {1'b1, 2'd1, 16'h0010, 1'b0, 20'h00000, 20'h00000},  // R3 20-bit truncation
    {1'b1, 2'd0, 16'hFFFF, 1'b1, 20'h2233F, 20'h12340},  // R6 offset wrap
    {1'b1, 2'd3, 16'h1234, 1'b1, 20'h02234, 20'h02235},  // R5 named data seg
    {1'b1, 2'd0, 16'h00FF, 1'b1, 20'h1243F, 20'h12440}   // R5 carry into base
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int          lat;
    int          n0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state at the ports
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(done == 1'b0 && mem_en == 1'b0 && wb_wait == 1'b0, "R1 idle outputs",
        int'({done, mem_en, wb_wait}), 0);

    // R1 code segment fetch at offset 0
    log_addr.delete(); log_we.delete(); log_data.delete();
    access(1'b1, 2'd1, 16'h0000, 2'd0, 1'b0, 16'h0, 1'b0, 16'h0, rd, lat);
    chk(log_addr.size() == 1 && log_addr[0] == 32'hFFFF0, "R1 reset fetch addr",
        log_addr.size() ? log_addr[0] : -1, 32'hFFFF0);
    chk(rd == {8'h00, pat(20'hFFFF0)}, "R3 byte read data", int'(rd), int'(pat(20'hFFFF0)));
    chk(lat == 2, "R8 byte latency", lat, 2);

    // R2 segment programming
    seg_write(2'd0, 16'h1234);
    seg_write(2'd2, 16'hF000);
    seg_write(2'd3, 16'h0100);

    for (int i = 0; i < NV; i++) begin
      logic        v_named = VEC[i][59];
      logic [1:0]  v_sel   = VEC[i][58:57];
      logic [15:0] v_off   = VEC[i][56:41];
      logic        v_word  = VEC[i][40];
      logic [19:0] v_lo    = VEC[i][39:20];
      logic [19:0] v_hi    = VEC[i][19:0];
      logic [15:0] exp_rd;
      log_addr.delete(); log_we.delete(); log_data.delete();
      access(v_named, v_sel, v_off, 2'd0, v_word, 16'h0, 1'b0, 16'h0, rd, lat);
      exp_rd = v_word ? {pat(v_hi), pat(v_lo)} : {8'h00, pat(v_lo)};
      chk(log_addr.size() == (v_word ? 2 : 1), "R5 R3 cycle count",
          log_addr.size(), v_word ? 2 : 1);
      if (log_addr.size() >= 1)
        chk(log_addr[0] == int'(v_lo), "R3 R4 low address", log_addr[0], int'(v_lo));
      if (v_word && log_addr.size() >= 2)
        chk(log_addr[1] == int'(v_hi), "R5 R6 R7 high address", log_addr[1], int'(v_hi));
      chk(rd == exp_rd, "R5 little-endian data", int'(rd), int'(exp_rd));
      chk(lat == (v_word ? 3 : 2), "R8 latency", lat, v_word ? 3 : 2);
    end

    // R2 a write on the accepting edge does not affect that request
    log_addr.delete(); log_we.delete(); log_data.delete();
    access(1'b0, 2'd0, 16'h0000, 2'd0, 1'b0, 16'h0, 1'b1, 16'h2000, rd, lat);
    chk(log_addr.size() == 1 && log_addr[0] == 32'h01000, "R2 old base same edge",
        log_addr.size() ? log_addr[0] : -1, 32'h01000);
    log_addr.delete(); log_we.delete(); log_data.delete();
    access(1'b0, 2'd2, 16'h0000, 2'd0, 1'b0, 16'h0, 1'b0, 16'h0, rd, lat);
    chk(log_addr.size() == 1 && log_addr[0] == 32'h20000, "R2 new base next request",
        log_addr.size() ? log_addr[0] : -1, 32'h20000);

    // R11 R6 word write across the segment end
    log_addr.delete(); log_we.delete(); log_data.delete();
    access(1'b1, 2'd0, 16'hFFFF, 2'd1, 1'b1, 16'hABCD, 1'b0, 16'h0, rd, lat);
    chk(log_addr.size() == 2 && log_we[0] && log_we[1], "R11 two write cycles",
        log_addr.size(), 2);
    chk(peek(20'h2233F) == 8'hCD, "R11 low byte stored", int'(peek(20'h2233F)), 8'hCD);
    chk(peek(20'h12340) == 8'hAB, "R11 R6 high byte stored", int'(peek(20'h12340)), 8'hAB);
    chk(lat == 3, "R8 word write latency", lat, 3);
    access(1'b1, 2'd0, 16'hFFFF, 2'd0, 1'b1, 16'h0, 1'b0, 16'h0, rd, lat);
    chk(rd == 16'hABCD, "R11 R5 word read back", int'(rd), 16'hABCD);

    // R3 byte write uses the low data byte only
    log_addr.delete(); log_we.delete(); log_data.delete();
    access(1'b0, 2'd0, 16'h0003, 2'd1, 1'b0, 16'h77EE, 1'b0, 16'h0, rd, lat);
    chk(log_addr.size() == 1 && log_data[0] == 8'hEE, "R3 byte write data",
        log_data.size() ? int'(log_data[0]) : -1, 8'hEE);
    chk(peek(20'h20004) == pat(20'h20004), "R3 byte write neighbour untouched",
        int'(peek(20'h20004)), int'(pat(20'h20004)));
    chk(lat == 2, "R8 byte write latency", lat, 2);

    // R9 read-modify-write of a word in the data segment (base 0x20000)
    log_addr.delete(); log_we.delete(); log_data.delete();
    @(negedge clk);
    req_valid = 1'b1; req_seg_named = 1'b0; req_offset = 16'h0010;
    req_op = 2'd2; req_word = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!wb_wait && lat < 20) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    chk(rdata == {pat(20'h20011), pat(20'h20010)}, "R9 read phase data",
        int'(rdata), int'({pat(20'h20011), pat(20'h20010)}));
    chk(done == 1'b0, "R9 no done during wait", int'(done), 0);
    n0 = log_addr.size();
    repeat (4) @(negedge clk);
    chk(log_addr.size() == n0 && wb_wait, "R10 quiet while waiting", log_addr.size(), n0);
    wb_valid = 1'b1; wb_data = 16'h5A3C;
    @(posedge clk);
    @(negedge clk);
    wb_valid = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    chk(lat == 3, "R9 write-back to done", lat, 3);
    chk(log_addr.size() == 4, "R9 four memory cycles", log_addr.size(), 4);
    if (log_addr.size() == 4) begin
      chk(log_addr[2] == 32'h20010 && log_we[2] && log_data[2] == 8'h3C,
          "R9 low write-back", log_addr[2], 32'h20010);
      chk(log_addr[3] == 32'h20011 && log_we[3] && log_data[3] == 8'h5A,
          "R9 high write-back", log_addr[3], 32'h20011);
    end

    // R10 idle: no memory cycles without a request
    n0 = log_addr.size();
    repeat (5) @(negedge clk);
    chk(log_addr.size() == n0 && !mem_en, "R10 idle quiet", log_addr.size(), n0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule